// File: doc/BRIEF.md
# Exception Link Address Generator

This block computes the two addresses that exception handling needs in a three-stage fetch, decode and execute pipeline with fixed 4-byte instructions. When an exception is taken it captures the link value, and it raises a one-cycle vector request that carries the cause. Later a return request makes it produce the corrected resume PC. The link value is always the PC at the moment of taking minus one instruction. Whether that PC has already moved one instruction past the normal fetch PC depends on the cause. The resume offset also depends on the cause: some causes continue after the instruction that raised them, and others re-execute it.

Six causes are handled: software interrupt, undefined instruction, normal interrupt, fast interrupt, prefetch abort and data abort. Several causes may be requested in one cycle; a fixed priority picks the one that is latched. The two interrupt causes are accepted only on a cycle that marks an instruction completion boundary. A small state machine sequences the block through three states. `ST_IDLE` waits for an exception. `ST_HELD` keeps the link value and cause until a return request arrives. `ST_RETURN` presents the resume PC for one cycle. The transitions are named *take* (ST_IDLE to ST_HELD, when a valid strobe carries an eligible cause), *return* (ST_HELD to ST_RETURN, on a return request) and *finish* (ST_RETURN to ST_IDLE, always after one cycle).

Top module: `exc_link_gen`

## Requirements
- R1: The link value is the PC at the moment of taking minus 4, modulo 2^32. That PC equals `fetch_pc` (which is `exec_addr` + 8) for software interrupt, undefined instruction and prefetch abort. It equals `fetch_pc` + 4 for normal interrupt, fast interrupt and data abort.
- R2: For a software interrupt (`cause_req` bit 0, code 1) or an undefined instruction (bit 1, code 2), the resume PC equals the link value.
- R3: For a normal interrupt (bit 2, code 3) or a fast interrupt (bit 3, code 4), the resume PC is the link value minus 4.
- R4: For a prefetch abort (bit 4, code 5), the resume PC is the link value minus 4, which is the faulting instruction itself.
- R5: For a data abort (bit 5, code 6), the resume PC is the link value minus 8, which is the faulting instruction itself.
- R6: When several eligible causes are requested together, only one is latched. The priority from highest to lowest is data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. `vec_cause` reports the winner's code; code 0 means none.
- R7: Interrupt causes (bits 2 and 3) are eligible only in a cycle with `instr_done` high. Without it they are not taken in that cycle, and a lower-priority synchronous cause may win instead.
- R8: A take in ST_IDLE makes `vec_req` high for exactly the following cycle. `link_out` and `vec_cause` are valid from that cycle and hold until the block returns to ST_IDLE.
- R9: A return request sampled in ST_HELD makes `resume_valid` high for exactly the following cycle, with `resume_pc` valid in that cycle.
- R10: In ST_HELD and ST_RETURN, exception strobes are ignored. In ST_IDLE, return requests are ignored.
- R11: The two low bits of `link_out` and `resume_pc` are always zero.
- R12: After reset the block is in ST_IDLE with `vec_req`, `resume_valid`, `vec_cause`, `link_out` and `resume_pc` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_addr | input | 32 | Address of the instruction in execute |
| fetch_pc | input | 32 | Current fetch PC, equal to exec_addr + 8 |
| exc_valid | input | 1 | Strobe: cause_req and the addresses are meaningful this cycle |
| cause_req | input | 6 | Requested causes, one bit per cause (bit positions in R2 to R5) |
| instr_done | input | 1 | The executing instruction completes this cycle |
| ret_req | input | 1 | Request to return from the held exception |
| vec_req | output | 1 | One-cycle vector request after a take |
| vec_cause | output | 3 | Code of the latched cause |
| link_out | output | 32 | Captured link value |
| resume_valid | output | 1 | resume_pc is valid this cycle |
| resume_pc | output | 32 | Corrected resume PC |

## Verification
The bench builds the block with its defaults: 32-bit addresses and 4-byte instructions. At that size it can sweep all 64 cause masks, each with the completion flag both low and high, at several execute addresses. Those addresses include zero and the top of the address space, so the wrap of the link and resume arithmetic in both directions is checked. Directed sequences cover return requests while idle and exception strobes while an exception is held.

// File: rtl/exc_link_pkg.sv
package exc_link_pkg;

    localparam int unsigned NUM_CAUSES = 6;

    localparam int unsigned BIT_SWI   = 0;
    localparam int unsigned BIT_UNDEF = 1;
    localparam int unsigned BIT_IRQ   = 2;
    localparam int unsigned BIT_FIQ   = 3;
    localparam int unsigned BIT_PABT  = 4;
    localparam int unsigned BIT_DABT  = 5;

    // highest priority first
    localparam int unsigned PRIO_ORDER [NUM_CAUSES] =
        '{BIT_DABT, BIT_FIQ, BIT_IRQ, BIT_PABT, BIT_UNDEF, BIT_SWI};

    typedef enum logic [2:0] {
        C_NONE  = 3'd0,
        C_SWI   = 3'd1,
        C_UNDEF = 3'd2,
        C_IRQ   = 3'd3,
        C_FIQ   = 3'd4,
        C_PABT  = 3'd5,
        C_DABT  = 3'd6
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_RETURN = 2'd2
    } state_e;

    function automatic logic is_async_bit(int unsigned b);
        return (b == BIT_IRQ) || (b == BIT_FIQ);
    endfunction

    // causes taken after the fetch PC has moved one more instruction
    function automatic logic pc_advanced(cause_e c);
        return (c == C_IRQ) || (c == C_FIQ) || (c == C_DABT);
    endfunction

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
    import exc_link_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] cause_req,
    input  logic                  instr_done,
    output logic [NUM_CAUSES-1:0] grant,
    output cause_e                grant_code
);

    logic [NUM_CAUSES-1:0] eligible;

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_elig
        if (is_async_bit(g)) begin : g_async
            assign eligible[g] = cause_req[g] & instr_done;
        end else begin : g_sync
            assign eligible[g] = cause_req[g];
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int k = 0; k < NUM_CAUSES; k++) begin
            if (!found && eligible[PRIO_ORDER[k]]) begin
                grant[PRIO_ORDER[k]] = 1'b1;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        grant_code = C_NONE;
        for (int i = 0; i < NUM_CAUSES; i++) begin
            if (grant[i]) grant_code = cause_e'(3'(i + 1));
        end
    end

endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
    import exc_link_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  cause_e            take_cause,
    input  cause_e            held_cause,
    input  logic [ADDR_W-1:0] held_link,
    output logic [ADDR_W-1:0] link_next,
    output logic [ADDR_W-1:0] resume_next
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = STEP - 1'b1;

    logic [ADDR_W-1:0] taken_pc;
    logic [ADDR_W-1:0] back_off;

    always_comb begin
        taken_pc  = pc_advanced(take_cause) ? (fetch_pc + STEP) : fetch_pc;
        link_next = (taken_pc - STEP) & ~ALIGN_MASK;
    end

    always_comb begin
        unique case (held_cause)
            C_SWI, C_UNDEF:        back_off = '0;
            C_IRQ, C_FIQ, C_PABT:  back_off = STEP;
            C_DABT:                back_off = STEP << 1;
            default:               back_off = '0;
        endcase
        resume_next = (held_link - back_off) & ~ALIGN_MASK;
    end

endmodule

// File: rtl/exc_link_fsm.sv
module exc_link_fsm
    import exc_link_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   take,
    input  logic   ret_req,
    output state_e state,
    output logic   capture_en,
    output logic   return_en
);

    state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        capture_en = 1'b0;
        return_en  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    capture_en = 1'b1;
                    state_nx   = ST_HELD;
                end
            end
            ST_HELD: begin
                if (ret_req) begin
                    return_en = 1'b1;
                    state_nx  = ST_RETURN;
                end
            end
            ST_RETURN: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    a_r9_return_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETURN) |=> (state == ST_IDLE));

    a_r10_held_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !ret_req) |=> (state == ST_HELD));

endmodule

// File: rtl/exc_link_gen.sv
module exc_link_gen
    import exc_link_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       exec_addr,
    input  logic [31:0]       fetch_pc,
    input  logic              exc_valid,
    input  logic [5:0]        cause_req,
    input  logic              instr_done,
    input  logic              ret_req,
    output logic              vec_req,
    output logic [2:0]        vec_cause,
    output logic [31:0]       link_out,
    output logic              resume_valid,
    output logic [31:0]       resume_pc
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = STEP - 1'b1;
    localparam logic [ADDR_W-1:0] PIPE_AHEAD = STEP << 1;
    localparam logic [NUM_CAUSES-1:0] SYNC_MASK =
        ~((NUM_CAUSES'(1) << BIT_IRQ) | (NUM_CAUSES'(1) << BIT_FIQ));

    logic [NUM_CAUSES-1:0] grant;
    cause_e                grant_code;
    state_e                state;
    logic                  capture_en;
    logic                  return_en;
    logic [ADDR_W-1:0]     link_next;
    logic [ADDR_W-1:0]     resume_next;
    logic [ADDR_W-1:0]     link_q;
    logic [ADDR_W-1:0]     resume_q;
    cause_e                cause_q;
    logic                  vec_q;

    exc_cause_arb u_arb (
        .cause_req  (cause_req),
        .instr_done (instr_done),
        .grant      (grant),
        .grant_code (grant_code)
    );

    exc_addr_calc #(
        .ADDR_W      (ADDR_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_calc (
        .fetch_pc    (fetch_pc),
        .take_cause  (grant_code),
        .held_cause  (cause_q),
        .held_link   (link_q),
        .link_next   (link_next),
        .resume_next (resume_next)
    );

    exc_link_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (exc_valid && (grant != '0)),
        .ret_req    (ret_req),
        .state      (state),
        .capture_en (capture_en),
        .return_en  (return_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_q   <= '0;
            cause_q  <= C_NONE;
            resume_q <= '0;
            vec_q    <= 1'b0;
        end else begin
            vec_q <= capture_en;
            if (capture_en) begin
                link_q  <= link_next;
                cause_q <= grant_code;
            end
            if (return_en) resume_q <= resume_next;
        end
    end

    always_comb begin
        vec_req      = vec_q;
        vec_cause    = cause_q;
        link_out     = link_q;
        resume_pc    = resume_q;
        resume_valid = (state == ST_RETURN);
    end

    // R1: input relation the link arithmetic relies on
    a_r1_pipe_relation: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (fetch_pc == exec_addr + PIPE_AHEAD));

    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r6_dabt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && exc_valid && cause_req[BIT_DABT]) |=>
        (vec_req && vec_cause == C_DABT));

    a_r7_defer_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && exc_valid && !instr_done &&
         (cause_req & SYNC_MASK) == '0) |=> !vec_req);

    a_r8_vec_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    a_r8_link_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |=> ($stable(link_out) && $stable(vec_cause)));

    a_r9_resume_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && ret_req) |=> resume_valid);

    a_r9_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |=> !resume_valid);

    a_r10_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !vec_req);

    a_r5_dabt_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_valid && vec_cause == C_DABT) |-> (resume_pc == link_out - PIPE_AHEAD));

    a_r11_align: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_out & ALIGN_MASK) == '0) && ((resume_pc & ALIGN_MASK) == '0));

endmodule

// File: tb/exc_link_gen_tb_top.sv
`timescale 1ns/1ps
module exc_link_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] exec_addr = '0;
    logic [31:0] fetch_pc = 32'd8;
    logic        exc_valid = 1'b0;
    logic [5:0]  cause_req = '0;
    logic        instr_done = 1'b0;
    logic        ret_req = 1'b0;
    logic        vec_req;
    logic [2:0]  vec_cause;
    logic [31:0] link_out;
    logic        resume_valid;
    logic [31:0] resume_pc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    exc_link_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_addr    (exec_addr),
        .fetch_pc     (fetch_pc),
        .exc_valid    (exc_valid),
        .cause_req    (cause_req),
        .instr_done   (instr_done),
        .ret_req      (ret_req),
        .vec_req      (vec_req),
        .vec_cause    (vec_cause),
        .link_out     (link_out),
        .resume_valid (resume_valid),
        .resume_pc    (resume_pc)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R6/R7: winning code from the priority list, interrupts gated by done
    function automatic int exp_code(logic [5:0] m, logic d);
        int order [6] = '{5, 3, 2, 4, 1, 0};
        foreach (order[k]) begin
            if (m[order[k]] && ((order[k] == 2 || order[k] == 3) ? d : 1'b1))
                return order[k] + 1;
        end
        return 0;
    endfunction

    // R1
    function automatic logic [31:0] exp_link(int code, logic [31:0] fpc);
        logic [31:0] pc;
        pc = (code == 3 || code == 4 || code == 6) ? fpc + 32'd4 : fpc;
        return pc - 32'd4;
    endfunction

    // R2..R5
    function automatic logic [31:0] exp_resume(int code, logic [31:0] lnk);
        case (code)
            1, 2:    return lnk;
            3, 4, 5: return lnk - 32'd4;
            6:       return lnk - 32'd8;
            default: return lnk;
        endcase
    endfunction

    function automatic string req_of(int code);
        case (code)
            1, 2:    return "R2";
            3, 4:    return "R3";
            5:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic trial(logic [31:0] a, logic [5:0] m, logic d);
        int code;
        logic [31:0] lnk;
        code = exp_code(m, d);
        lnk  = exp_link(code, a + 32'd8);
        @(negedge clk);
        exec_addr  = a;
        fetch_pc   = a + 32'd8;
        cause_req  = m;
        instr_done = d;
        exc_valid  = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
        cause_req = '0;
        instr_done = 1'b0;
        check("R8_vec_req", 32'(vec_req), (code != 0) ? 32'd1 : 32'd0);
        if (code != 0) begin
            check("R6_R7_cause", 32'(vec_cause), 32'(code));
            check("R1_link", link_out, lnk);
            check("R11_link_align", 32'(link_out[1:0]), 32'd0);
            ret_req = 1'b1;
            @(negedge clk);
            ret_req = 1'b0;
            check("R9_resume_valid", 32'(resume_valid), 32'd1);
            check(req_of(code), resume_pc, exp_resume(code, lnk));
            check("R8_pulse_and_hold", {vec_req, link_out[30:0]}, {1'b0, lnk[30:0]});
            @(negedge clk);
            check("R9_resume_pulse", 32'(resume_valid), 32'd0);
        end
    endtask

    initial begin
        logic [31:0] addrs [5] = '{32'h0000_1000, 32'h0000_0000, 32'hFFFF_FFF8,
                                   32'hFFFF_FFFC, 32'h7FFF_0FF4};
        repeat (3) @(negedge clk);
        // R12: reset values
        check("R12_vec_req", 32'(vec_req), 32'd0);
        check("R12_resume_valid", 32'(resume_valid), 32'd0);
        check("R12_cause", 32'(vec_cause), 32'd0);
        check("R12_link", link_out, 32'd0);
        check("R12_resume_pc", resume_pc, 32'd0);
        rst_n = 1'b1;

        // R10: return request in idle is ignored
        @(negedge clk);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        check("R10_ret_in_idle", 32'(resume_valid), 32'd0);

        // R7: interrupt alone without a completion boundary is not taken
        trial(32'h0000_2000, 6'b000100, 1'b0);
        trial(32'h0000_2000, 6'b001000, 1'b0);

        // R10: exception strobe while held is ignored
        @(negedge clk);
        exec_addr = 32'h0000_4000; fetch_pc = 32'h0000_4008;
        cause_req = 6'b000001; exc_valid = 1'b1;
        @(negedge clk);
        exec_addr = 32'h0000_8000; fetch_pc = 32'h0000_8008;
        cause_req = 6'b100000; exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0; cause_req = '0;
        check("R10_no_second_vec", 32'(vec_req), 32'd0);
        check("R10_cause_kept", 32'(vec_cause), 32'd1);
        check("R10_link_kept", link_out, 32'h0000_4004);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        check("R2_after_ignored", resume_pc, 32'h0000_4004);
        @(negedge clk);

        // sweep: all masks, both done values, several addresses (R1..R7, R11)
        foreach (addrs[ai]) begin
            for (int m = 0; m < 64; m++) begin
                for (int d = 0; d < 2; d++) begin
                    trial(addrs[ai], 6'(m), 1'(d));
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule